// File: doc/BRIEF.md
# Sliced Condition-and-Combine Arithmetic Unit

This block is a purely combinational arithmetic unit for a narrow processor datapath. It is built from one identical slice per data bit. Each slice receives one bit of each conditioned operand and a carry from the slice below, and it produces one result bit and a carry for the slice above. The carry into the lowest slice is tied low, so the carries ripple from bit 0 to the top bit.

Six shared control inputs shape the operation:

- Each operand has a clear control, applied first, and an invert control, applied second.
- A selector picks either the bitwise AND of the two conditioned operands or their sum.
- A final control optionally inverts the selected value.

By combining these controls, the two core operations give many useful functions, such as negation, increment, decrement, subtraction, OR and constants. Alongside the result, the block reports three flags: the carry out of the top slice, an all-zero flag and a sign flag.

Top module: `bsalu_top`

## Requirements
- R1: With `clr_a`=1, operand A is replaced by all zeros before any inversion; with `clr_a`=1 and `flip_a`=0 the conditioned A is 0.
- R2: With `flip_a`=1, the (possibly cleared) operand A is bitwise inverted; with both `clr_a` and `flip_a` set the conditioned A is all ones.
- R3: Operand B is conditioned by `clr_b` then `flip_b` in exactly the same order and manner as A.
- R4: With `use_sum`=0, the pre-inversion value is the bitwise AND of the two conditioned operands.
- R5: With `use_sum`=1, the pre-inversion value is the low WIDTH bits of the sum of the two conditioned operands, with carry into bit 0 equal to 0.
- R6: With `flip_out`=1, `res` is the bitwise inverse of the pre-inversion value; with `flip_out`=0 it equals that value.
- R7: With `use_sum`=1, `cout` equals bit WIDTH of the (WIDTH+1)-bit sum of the conditioned operands, and is not affected by `flip_out`.
- R8: `zero` is 1 exactly when every bit of `res` is 0.
- R9: `neg` equals the most significant bit of `res`.
- R10: With all conditioning controls clear, `use_sum`=1 and `flip_out`=0, inputs 6357 and 1177 give `res`=7534.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| clr_a | input | 1 | Clear first operand |
| flip_a | input | 1 | Invert first operand after clearing |
| clr_b | input | 1 | Clear second operand |
| flip_b | input | 1 | Invert second operand after clearing |
| use_sum | input | 1 | 1 selects sum, 0 selects bitwise AND |
| flip_out | input | 1 | Invert the selected value |
| res | output | WIDTH | Result |
| cout | output | 1 | Carry out of the top slice |
| zero | output | 1 | All result bits are zero |
| neg | output | 1 | Most significant result bit |

## Verification
The bench builds the unit with the default WIDTH of 16, which keeps all 64 control combinations small enough to sweep completely. Each combination is applied to every pairing of the corner operands 0, 0xFFFF, 0x8000 and 0x7FFF, and to a set of random pairs. This exposes the full-length carry ripple, the sign boundary and the clear-then-invert ordering in every mode. Directed vectors isolate each operand's conditioning and the 6357 + 1177 sum.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
    typedef struct packed {
        logic clr_a;
        logic flip_a;
        logic clr_b;
        logic flip_b;
        logic use_sum;
        logic flip_out;
    } bsalu_ctrl_t;
endpackage

// File: rtl/bsalu_opnd_cond.sv
module bsalu_opnd_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             clr,
    input  logic             flip,
    output logic [WIDTH-1:0] cond
);
    // clear first, then invert (R1, R2, R3)
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            cond[i] = (raw[i] & ~clr) ^ flip;
        end
    end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice (
    input  logic a,
    input  logic b,
    input  logic cin,
    input  logic use_sum,
    input  logic flip_out,
    output logic r,
    output logic cout
);
    logic gen;
    logic prop;
    logic pre;

    always_comb begin
        gen  = a & b;
        prop = a ^ b;
        cout = gen | (prop & cin);
        pre  = use_sum ? (prop ^ cin) : gen;   // AND term reuses generate
        r    = pre ^ flip_out;
    end
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] value,
    output logic             zero,
    output logic             neg
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        zero = ~|value;
        neg  = value[MSB];
    end
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             clr_a,
    input  logic             flip_a,
    input  logic             clr_b,
    input  logic             flip_b,
    input  logic             use_sum,
    input  logic             flip_out,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             zero,
    output logic             neg
);
    import bsalu_pkg::*;

    bsalu_ctrl_t      ctl;
    logic [WIDTH-1:0] a_c;
    logic [WIDTH-1:0] b_c;
    logic [WIDTH:0]   carry;

    always_comb begin
        ctl.clr_a    = clr_a;
        ctl.flip_a   = flip_a;
        ctl.clr_b    = clr_b;
        ctl.flip_b   = flip_b;
        ctl.use_sum  = use_sum;
        ctl.flip_out = flip_out;
    end

    bsalu_opnd_cond #(.WIDTH(WIDTH)) u_cond_a (
        .raw(a_in), .clr(ctl.clr_a), .flip(ctl.flip_a), .cond(a_c)
    );
    bsalu_opnd_cond #(.WIDTH(WIDTH)) u_cond_b (
        .raw(b_in), .clr(ctl.clr_b), .flip(ctl.flip_b), .cond(b_c)
    );

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        bsalu_slice u_slice (
            .a(a_c[i]), .b(b_c[i]), .cin(carry[i]),
            .use_sum(ctl.use_sum), .flip_out(ctl.flip_out),
            .r(res[i]), .cout(carry[i+1])
        );
    end

    assign cout = carry[WIDTH];

    bsalu_flags #(.WIDTH(WIDTH)) u_flags (
        .value(res), .zero(zero), .neg(neg)
    );
endmodule

// File: rtl/bsalu_checker.sv
module bsalu_checker #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             clr_a,
    input logic             flip_a,
    input logic             clr_b,
    input logic             flip_b,
    input logic             use_sum,
    input logic             flip_out,
    input logic [WIDTH-1:0] res,
    input logic             cout,
    input logic             zero,
    input logic             neg
);
    logic [WIDTH-1:0] ra;
    logic [WIDTH-1:0] rb;
    logic [WIDTH:0]   wide;

    always_comb begin
        ra   = clr_a ? '0 : a_in;
        ra   = flip_a ? ~ra : ra;
        rb   = clr_b ? '0 : b_in;
        rb   = flip_b ? ~rb : rb;
        wide = {1'b0, ra} + {1'b0, rb};

        if (!use_sum) begin
            assert_and_mode_R4: assert (res == ((ra & rb) ^ {WIDTH{flip_out}}))
                else $error("and-mode result mismatch");
        end else begin
            assert_sum_mode_R5: assert (res == (wide[WIDTH-1:0] ^ {WIDTH{flip_out}}))
                else $error("sum-mode result mismatch");
            assert_carry_R7: assert (cout == wide[WIDTH])
                else $error("carry mismatch");
        end
        assert_zero_flag_R8: assert (zero == (res == '0))
            else $error("zero flag mismatch");
        assert_sign_flag_R9: assert (neg == res[WIDTH-1])
            else $error("sign flag mismatch");
    end
endmodule

bind bsalu_top bsalu_checker #(.WIDTH(WIDTH)) u_bsalu_chk (
    .a_in(a_in), .b_in(b_in), .clr_a(clr_a), .flip_a(flip_a),
    .clr_b(clr_b), .flip_b(flip_b), .use_sum(use_sum), .flip_out(flip_out),
    .res(res), .cout(cout), .zero(zero), .neg(neg)
);

// File: tb/test_bsalu_top.sv
module test_bsalu_top;
    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         clr_a = 1'b0, flip_a = 1'b0, clr_b = 1'b0, flip_b = 1'b0;
    logic         use_sum = 1'b0, flip_out = 1'b0;
    logic [W-1:0] res;
    logic         cout, zero, neg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsalu_top #(.WIDTH(W)) i_bsalu_top (
        .a_in(a_in), .b_in(b_in), .clr_a(clr_a), .flip_a(flip_a),
        .clr_b(clr_b), .flip_b(flip_b), .use_sum(use_sum), .flip_out(flip_out),
        .res(res), .cout(cout), .zero(zero), .neg(neg)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        {clr_a, flip_a, clr_b, flip_b, use_sum, flip_out} = c;
        a_in = x;
        b_in = y;
        #1;
    endtask

    // full model check of one vector
    task automatic model_check(input logic [5:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] xa, yb, pre, exp_r;
        logic [W:0]   s;
        apply(c, x, y);
        xa = c[5] ? 16'h0000 : x;  if (c[4]) xa = ~xa;
        yb = c[3] ? 16'h0000 : y;  if (c[2]) yb = ~yb;
        s   = {1'b0, xa} + {1'b0, yb};
        pre = c[1] ? s[W-1:0] : (xa & yb);
        exp_r = c[0] ? ~pre : pre;
        chk("R1/R2/R3/R4/R5/R6 sweep res", res, exp_r);
        if (c[1]) chk("R7 sweep cout", {15'd0, cout}, {15'd0, s[W]});
        chk("R8 sweep zero", {15'd0, zero}, {15'd0, exp_r == 16'h0000});
        chk("R9 sweep neg", {15'd0, neg}, {15'd0, exp_r[W-1]});
    endtask

    initial begin
        logic [W-1:0] corner [4];
        logic [W-1:0] rx [NRAND];
        logic [W-1:0] ry [NRAND];
        corner[0] = 16'h0000; corner[1] = 16'hFFFF;
        corner[2] = 16'h8000; corner[3] = 16'h7FFF;
        for (int i = 0; i < NRAND; i++) begin
            rx[i] = 16'($urandom());
            ry[i] = 16'($urandom());
        end
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // idle state: all inputs low gives zero AND
        apply(6'b000000, 16'h0000, 16'h0000);
        chk("R4 idle res", res, 16'h0000);
        chk("R8 idle zero", {15'd0, zero}, 16'd1);

        // R1: clear without invert
        apply(6'b100010, 16'hFFFF, 16'h0000);
        chk("R1 clear a", res, 16'h0000);
        // R2: clear then invert gives all ones
        apply(6'b110000, 16'h1234, 16'hFFFF);
        chk("R2 clear+flip a", res, 16'hFFFF);
        // R3: clear then invert on b, AND with a
        apply(6'b001100, 16'h1234, 16'h5A5A);
        chk("R3 clear+flip b", res, 16'h1234);
        // R6: inversion of AND
        apply(6'b000001, 16'hF0F0, 16'hFF00);
        chk("R6 flip out", res, 16'h0FFF);
        // R7: carry not touched by flip_out
        apply(6'b000011, 16'hFFFF, 16'h0001);
        chk("R7 carry with flip", {15'd0, cout}, 16'd1);
        chk("R6 flip of zero sum", res, 16'hFFFF);
        // R10
        apply(6'b000010, 16'd6357, 16'd1177);
        chk("R10 known sum", res, 16'd7534);
        chk("R9 known sum sign", {15'd0, neg}, 16'd0);

        for (int c = 0; c < 64; c++) begin
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    model_check(6'(c), corner[i], corner[j]);
            for (int k = 0; k < NRAND; k++)
                model_check(6'(c), rx[k], ry[k]);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule